// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block holds the interrupt and register-pointer logic of a two-channel (A and B) serial controller. A host reaches each channel through a byte-wide control port and a byte-wide data port. Control accesses go through a per-channel register pointer. While the pointer is zero, a control write loads it and can also issue a command. Any other control access uses the selected register and then returns the pointer to zero.

Each channel tracks a receive-pending flag, a transmit-pending flag and an under-service flag for each of them. Received bytes arrive from a neighbouring receiver on a push strobe, and break conditions arrive on a set strobe. A data write stands for a byte handed to the transmitter, which is at once taken as sent. Both channels drive one shared interrupt line. They also feed two shared readable registers: an interrupt vector, read as register 2 of channel B, and a pending-bits register, read as register 3 of channel A. Receive service takes priority over transmit service. The vector has a low-bits and a high-bits encoding, chosen per channel.

Top module: `sio_irq_ctl`

## Requirements
- R1: While a channel's pointer is 0, a control write sets the pointer to data bits 2:0, plus 8 when bits 5:3 equal 001. A control write made with a nonzero pointer, and every control read, leaves the pointer at 0.
- R2: After reset: register 0 (status) reads 0x44 and register 1 reads 0x07 on both channels. The vector reads 0x00, the pending bits read 0x00 and `irq` is low. Break interrupts are enabled (register 15 bit 7), the low vector variant is selected (register 9 = 0xC0), and receive is disabled.
- R3: `irq` is the OR over both channels of three terms: register 1 bit 1 AND transmit pending; register 1 bits 4:3 equal to 01 or 10 AND receive pending; register 15 bit 7 AND break status.
- R4: With register 9 bit 4 clear, the vector codes are A receive 0x0C, B receive 0x04, A transmit 0x08, B transmit 0x00 and none 0x06.
- R5: With register 9 bit 4 set, the vector codes are A receive 0x30, B receive 0x20, A transmit 0x10, B transmit 0x00 and none 0x60.
- R6: Pending bits (register 3 of A) are: bit 1 B transmit, bit 2 B receive, bit 4 A transmit, bit 5 A receive; bits 0 and 3 read 0. A transmit bit is set only when register 1 bit 1 is set.
- R7: While a receive interrupt is under service, a new transmit interrupt stays pending. It does not change the vector or its pending bit.
- R8: Command 0x38 ends receive service and then raises any pending transmit interrupt. If no receive interrupt is under service, it ends transmit service instead, leaving the vector unchanged.
- R9: Command 0x28 clears the transmit interrupt and its pending bit, and sets the vector to "none". If a receive interrupt is still pending, that receive interrupt is raised again.
- R10: A data write raises the transmit interrupt, and status bit 2 (transmit empty) reads 1. A data read returns the last received byte, clears status bit 0 (receive available) and clears the receive interrupt.
- R11: A receive push sets status bit 0 and raises the receive interrupt. A push is ignored when register 3 bit 0 is 0 or when a byte is already available.
- R12: Writing register 9 with bits 7:6 = 01 resets channel B, 10 resets channel A and 11 resets both. Resetting B sets the vector to 0x00. Resetting a channel clears its pending bits. With bits 7:6 = 00 the value is stored.
- R13: When both channels update the vector in the same cycle, channel A's code is kept.
- R14: A break strobe sets status bit 7 of that channel. The break stays set until that channel is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_en | input | 1 | Host access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel_a | input | 1 | 1 = channel A, 0 = channel B |
| acc_ctrl | input | 1 | 1 = control port, 0 = data port |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data of the selected channel and port |
| rx_push | input | 2 | Receive byte strobe, bit 1 = A, bit 0 = B |
| rx_data_a | input | 8 | Received byte for channel A |
| rx_data_b | input | 8 | Received byte for channel B |
| brk_set | input | 2 | Break detected strobe, bit 1 = A, bit 0 = B |
| irq | output | 1 | Shared interrupt request |

## Verification
The hardest state to reach is a transmit interrupt held back behind receive service. The stimulus builds it in order: a received byte on channel A, then a data write on A while the receive is still under service. Next, two reset-highest commands and a data read check each step of release. The other hard case is channel A and channel B updating the vector in the same cycle. The bench drives a data write on B and a receive push on A on the same clock edge.

// File: rtl/sio_irq_pkg.sv
// Shared types, command codes and the vector encoding of the serial
// interrupt controller. Assumes two channels, index 1 = A, index 0 = B.
package sio_irq_pkg;

    localparam int DW    = 8;
    localparam int PTR_W = 4;
    localparam int NCH   = 2;

    localparam logic [2:0] CMD_HIGH_BANK = 3'b001;
    localparam logic [2:0] CMD_CLR_TX    = 3'b101;
    localparam logic [2:0] CMD_RST_IUS   = 3'b111;

    typedef enum logic [1:0] {VK_NONE, VK_RX, VK_TX} vkind_e;

    // Per-channel interrupt state plus the shared-register request it produces
    typedef struct packed {
        logic       rxint;
        logic       txint;
        logic       rxus;
        logic       txus;
        logic       vreq;
        vkind_e     vk;
        logic [1:0] ps;   // pending set   [1]=rx [0]=tx
        logic [1:0] pc;   // pending clear [1]=rx [0]=tx
    } ist_t;

    function automatic logic [DW-1:0] vec_code(input logic is_a, input vkind_e k,
                                               input logic hi);
        logic [DW-1:0] c;
        case (k)
            VK_RX:   c = is_a ? (hi ? 8'h30 : 8'h0C) : (hi ? 8'h20 : 8'h04);
            VK_TX:   c = is_a ? (hi ? 8'h10 : 8'h08) : 8'h00;
            default: c = hi ? 8'h60 : 8'h06;
        endcase
        return c;
    endfunction

    function automatic ist_t op_set_rx(input ist_t s);
        ist_t r = s;
        r.rxint = 1'b1;
        r.rxus  = 1'b1;
        r.ps[1] = 1'b1;
        r.pc[1] = 1'b0;
        r.vreq  = 1'b1;
        r.vk    = VK_RX;
        return r;
    endfunction

    function automatic ist_t op_set_tx(input ist_t s, input logic tx_en);
        ist_t r = s;
        r.txint = 1'b1;
        if (!r.rxus) begin
            r.txus = 1'b1;
            if (tx_en) begin
                r.ps[0] = 1'b1;
                r.pc[0] = 1'b0;
            end
            r.vreq = 1'b1;
            r.vk   = VK_TX;
        end
        return r;
    endfunction

    function automatic ist_t op_clr_rx(input ist_t s, input logic tx_en);
        ist_t r = s;
        r.rxint = 1'b0;
        r.rxus  = 1'b0;
        r.pc[1] = 1'b1;
        r.ps[1] = 1'b0;
        r.vreq  = 1'b1;
        r.vk    = VK_NONE;
        if (r.txint) r = op_set_tx(r, tx_en);
        return r;
    endfunction

    function automatic ist_t op_clr_tx(input ist_t s);
        ist_t r = s;
        r.txint = 1'b0;
        r.txus  = 1'b0;
        r.pc[0] = 1'b1;
        r.ps[0] = 1'b0;
        r.vreq  = 1'b1;
        r.vk    = VK_NONE;
        if (r.rxint) r = op_set_rx(r);
        return r;
    endfunction

endpackage

// File: rtl/sio_chan.sv
// One serial channel: register pointer, write registers, status, and the
// receive/transmit pending and under-service flags. Emits vector and
// pending-bit requests for the shared arbiter. Assumes at most one host
// access per cycle; within a cycle the access acts first, then a push.
module sio_chan
    import sio_irq_pkg::*;
#(
    parameter bit IS_A = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             acc_wr,
    input  logic             acc_ctrl,
    input  logic [DW-1:0]    wdata,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             brk_in,
    input  logic             crst,
    input  logic [DW-1:0]    vec_q,
    input  logic [5:0]       pend_q,
    output logic [DW-1:0]    rdata,
    output logic [1:0]       rst_req,
    output logic             vreq,
    output logic [DW-1:0]    vcode,
    output logic [1:0]       pset,
    output logic [1:0]       pclr,
    output logic             irq_term
);

    localparam logic [DW-1:0] WR9_RST  = 8'hC0;
    localparam logic [DW-1:0] WR15_RST = 8'hF8;
    localparam logic [DW-1:0] RR1_VAL  = 8'h07;

    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic [DW-1:0]    wr1_q, wr1_d, wr9_q, wr9_d, wr15_q, wr15_d;
    logic             rxen_q, rxen_d;
    logic             avail_q, avail_d, brk_q, brk_d;
    logic [DW-1:0]    rxbuf_q, rxbuf_d;
    ist_t             st_q, st_d;
    logic [DW-1:0]    rr0;
    logic [2:0]       cmd;

    assign cmd = wdata[5:3];
    assign rr0 = {brk_q, 1'b1, 3'b000, 1'b1, 1'b0, avail_q};

    // Next-state of pointer, registers and interrupt flags for this cycle
    always_comb begin
        ist_t s;
        ptr_d   = ptr_q;
        wr1_d   = wr1_q;
        wr9_d   = wr9_q;
        wr15_d  = wr15_q;
        rxen_d  = rxen_q;
        avail_d = avail_q;
        brk_d   = brk_q;
        rxbuf_d = rxbuf_q;
        rst_req = 2'b00;
        s       = st_q;
        s.vreq  = 1'b0;
        s.vk    = VK_NONE;
        s.ps    = 2'b00;
        s.pc    = 2'b00;
        if (hit && acc_ctrl) begin
            if (acc_wr && ptr_q == '0) begin
                ptr_d = {cmd == CMD_HIGH_BANK, wdata[2:0]};
                if (cmd == CMD_CLR_TX) begin
                    s = op_clr_tx(s);
                end else if (cmd == CMD_RST_IUS) begin
                    if (s.rxus) begin
                        s.rxus = 1'b0;
                        if (s.txint) s = op_set_tx(s, wr1_q[1]);
                    end else if (s.txus) begin
                        s.txus = 1'b0;
                    end
                end
            end else begin
                ptr_d = '0;
                if (acc_wr) begin
                    case (ptr_q)
                        4'd1:    wr1_d  = wdata;
                        4'd3:    rxen_d = wdata[0];
                        4'd9:    if (wdata[7:6] == 2'b00) wr9_d = wdata;
                                 else rst_req = wdata[7:6];
                        4'd15:   wr15_d = wdata;
                        default: ;
                    endcase
                end
            end
        end else if (hit && acc_wr) begin
            s = op_set_tx(s, wr1_q[1]);
        end else if (hit) begin
            avail_d = 1'b0;
            s       = op_clr_rx(s, wr1_q[1]);
        end
        if (push && rxen_q && !avail_d) begin
            avail_d = 1'b1;
            rxbuf_d = push_data;
            s       = op_set_rx(s);
        end
        if (brk_in) brk_d = 1'b1;
        st_d = s;
    end

    // Register update; a channel reset from either side wins over all events
    always_ff @(posedge clk) begin
        if (!rst_n || crst) begin
            ptr_q   <= '0;
            wr1_q   <= '0;
            wr9_q   <= WR9_RST;
            wr15_q  <= WR15_RST;
            rxen_q  <= 1'b0;
            avail_q <= 1'b0;
            brk_q   <= 1'b0;
            rxbuf_q <= '0;
            st_q    <= '0;
        end else begin
            ptr_q   <= ptr_d;
            wr1_q   <= wr1_d;
            wr9_q   <= wr9_d;
            wr15_q  <= wr15_d;
            rxen_q  <= rxen_d;
            avail_q <= avail_d;
            brk_q   <= brk_d;
            rxbuf_q <= rxbuf_d;
            st_q    <= st_d;
        end
    end

    // Requests to the shared arbiter, suppressed while this channel resets
    assign vreq  = st_d.vreq & ~crst;
    assign vcode = vec_code(IS_A, st_d.vk, wr9_q[4]);
    assign pset  = crst ? 2'b00 : st_d.ps;
    assign pclr  = crst ? 2'b00 : st_d.pc;

    // This channel's share of the interrupt line
    assign irq_term = (wr1_q[1] & st_q.txint)
                    | (((wr1_q[4:3] == 2'b01) || (wr1_q[4:3] == 2'b10)) & st_q.rxint)
                    | (wr15_q[7] & brk_q);

    // Read data of the register the pointer selects, or the receive byte
    always_comb begin
        if (!acc_ctrl) begin
            rdata = rxbuf_q;
        end else begin
            case (ptr_q)
                4'd0:    rdata = rr0;
                4'd1:    rdata = RR1_VAL;
                4'd2:    rdata = IS_A ? '0 : vec_q;
                4'd3:    rdata = IS_A ? {2'b00, pend_q} : '0;
                default: rdata = '0;
            endcase
        end
    end

    // R1: pointer is back at 0 after any access that does not load it
    a_r1_ptr_return: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && acc_ctrl && (!acc_wr || ptr_q != '0)) |=> (ptr_q == '0));

    // R10: a data read without a concurrent push leaves no byte available
    a_r10_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !acc_ctrl && !acc_wr && !push) |=> !avail_q);

endmodule

// File: rtl/sio_vec_arb.sv
// Shared vector and pending-bits registers. Merges requests from both
// channels; channel A wins a vector conflict. Assumes index 1 = A.
module sio_vec_arb
    import sio_irq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           vreq,
    input  logic [NCH-1:0][DW-1:0]   vcode,
    input  logic [NCH-1:0][1:0]      pset,
    input  logic [NCH-1:0][1:0]      pclr,
    input  logic [NCH-1:0]           crst,
    output logic [DW-1:0]            vec_q,
    output logic [5:0]               pend_q
);

    logic [DW-1:0] vec_d;
    logic [5:0]    pend_d;

    // Per-channel pending-bit field update; bit base+1 = tx, base+2 = rx
    always_comb begin
        pend_d = pend_q;
        for (int c = 0; c < NCH; c++) begin
            if (crst[c]) begin
                pend_d[c*3 +: 3] = 3'b000;
            end else begin
                pend_d[c*3 + 1] = (pend_q[c*3 + 1] & ~pclr[c][0]) | pset[c][0];
                pend_d[c*3 + 2] = (pend_q[c*3 + 2] & ~pclr[c][1]) | pset[c][1];
                pend_d[c*3]     = 1'b0;
            end
        end
    end

    // Vector selection with channel A taking precedence
    always_comb begin
        if (vreq[1])      vec_d = vcode[1];
        else if (vreq[0]) vec_d = vcode[0];
        else if (crst[0]) vec_d = '0;
        else              vec_d = vec_q;
    end

    // Shared register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            pend_q <= '0;
        end else begin
            vec_q  <= vec_d;
            pend_q <= pend_d;
        end
    end

    // R13: channel A's code survives a same-cycle conflict
    a_r13_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (vreq == 2'b11) |=> (vec_q == $past(vcode[1])));

    // R4: the vector only ever holds a defined code
    a_r4_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_q == 8'h00 || vec_q == 8'h04 || vec_q == 8'h06 || vec_q == 8'h08 ||
         vec_q == 8'h0C || vec_q == 8'h10 || vec_q == 8'h20 || vec_q == 8'h30 ||
         vec_q == 8'h60));

endmodule

// File: rtl/sio_irq_ctl.sv
// Top of the dual-channel serial interrupt controller: routes host
// accesses, receive pushes and break strobes to two channels, collects
// channel resets and drives the shared interrupt line and read data.
module sio_irq_ctl
    import sio_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_wr,
    input  logic          acc_sel_a,
    input  logic          acc_ctrl,
    input  logic [7:0]    acc_wdata,
    output logic [7:0]    acc_rdata,
    input  logic [1:0]    rx_push,
    input  logic [7:0]    rx_data_a,
    input  logic [7:0]    rx_data_b,
    input  logic [1:0]    brk_set,
    output logic          irq
);

    logic [NCH-1:0]           hit, vreq, irq_term, crst;
    logic [NCH-1:0][DW-1:0]   vcode, rd;
    logic [NCH-1:0][1:0]      pset, pclr, rreq;
    logic [DW-1:0]            vec_q;
    logic [5:0]               pend_q;

    // Channel resets requested by a register-9 write on either channel
    assign crst = rreq[0] | rreq[1];

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign hit[c] = acc_en & (acc_sel_a == (c == 1));
            sio_chan #(.IS_A(c == 1)) i_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .hit       (hit[c]),
                .acc_wr    (acc_wr),
                .acc_ctrl  (acc_ctrl),
                .wdata     (acc_wdata),
                .push      (rx_push[c]),
                .push_data ((c == 1) ? rx_data_a : rx_data_b),
                .brk_in    (brk_set[c]),
                .crst      (crst[c]),
                .vec_q     (vec_q),
                .pend_q    (pend_q),
                .rdata     (rd[c]),
                .rst_req   (rreq[c]),
                .vreq      (vreq[c]),
                .vcode     (vcode[c]),
                .pset      (pset[c]),
                .pclr      (pclr[c]),
                .irq_term  (irq_term[c])
            );
        end
    endgenerate

    sio_vec_arb i_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .vreq   (vreq),
        .vcode  (vcode),
        .pset   (pset),
        .pclr   (pclr),
        .crst   (crst),
        .vec_q  (vec_q),
        .pend_q (pend_q)
    );

    assign acc_rdata = acc_sel_a ? rd[1] : rd[0];
    assign irq       = |irq_term;

    // R2: the line is quiet in the first cycle after reset
    a_r2_irq_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !irq);

    // R6: external pending positions never set
    a_r6_ext_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[0] == 1'b0) && (pend_q[3] == 1'b0));

endmodule

// File: tb/test_sio_irq_ctl.sv
module test_sio_irq_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0, acc_wr = 1'b0, acc_sel_a = 1'b0, acc_ctrl = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic [1:0] rx_push = '0;
    logic [7:0] rx_data_a = '0, rx_data_b = '0;
    logic [1:0] brk_set = '0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] v;

    always #10 clk = ~clk;

    sio_irq_ctl i_sio_irq_ctl (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_sel_a(acc_sel_a), .acc_ctrl(acc_ctrl), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .rx_push(rx_push), .rx_data_a(rx_data_a),
        .rx_data_b(rx_data_b), .brk_set(brk_set), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic a, input logic ctrl, input logic wr,
                       input logic [7:0] d, output logic [7:0] rd);
        @(negedge clk);
        acc_en = 1'b1; acc_sel_a = a; acc_ctrl = ctrl; acc_wr = wr; acc_wdata = d;
        #1 rd = acc_rdata;
        @(posedge clk);
        #1 acc_en = 1'b0;
    endtask

    task automatic ctl_wr(input logic a, input logic [7:0] d);
        logic [7:0] x;
        acc(a, 1'b1, 1'b1, d, x);
    endtask

    task automatic ctl_rd(input logic a, output logic [7:0] rd);
        acc(a, 1'b1, 1'b0, 8'h00, rd);
    endtask

    task automatic dat_wr(input logic a, input logic [7:0] d);
        logic [7:0] x;
        acc(a, 1'b0, 1'b1, d, x);
    endtask

    task automatic dat_rd(input logic a, output logic [7:0] rd);
        acc(a, 1'b0, 1'b0, 8'h00, rd);
    endtask

    task automatic wr_reg(input logic a, input int n, input logic [7:0] d);
        ctl_wr(a, (n >= 8) ? (8'((n & 7) | 8)) : 8'(n));
        ctl_wr(a, d);
    endtask

    task automatic rd_reg(input logic a, input int n, output logic [7:0] rd);
        if (n != 0) ctl_wr(a, (n >= 8) ? (8'((n & 7) | 8)) : 8'(n));
        ctl_rd(a, rd);
    endtask

    task automatic push(input logic a, input logic [7:0] d);
        @(negedge clk);
        if (a) begin rx_push[1] = 1'b1; rx_data_a = d; end
        else   begin rx_push[0] = 1'b1; rx_data_b = d; end
        @(posedge clk);
        #1 rx_push = '0;
    endtask

    task automatic chk_vec(input string tag, input logic [7:0] e);
        logic [7:0] x;
        rd_reg(1'b0, 2, x);
        chk(tag, x, e);
    endtask

    task automatic chk_pend(input string tag, input logic [7:0] e);
        logic [7:0] x;
        rd_reg(1'b1, 3, x);
        chk(tag, x, e);
    endtask

    task automatic t_reset;
        logic [7:0] x;
        rd_reg(1'b1, 0, x); chk("R2 A status", x, 8'h44);
        rd_reg(1'b0, 0, x); chk("R2 B status", x, 8'h44);
        rd_reg(1'b1, 1, x); chk("R2 A reg1", x, 8'h07);
        chk_vec("R2 vector", 8'h00);
        chk_pend("R2 pending", 8'h00);
        chk("R2 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_push_disabled;
        logic [7:0] x;
        push(1'b0, 8'h77);
        rd_reg(1'b0, 0, x); chk("R11 push ignored rx off", x, 8'h44);
        chk("R11 irq quiet", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_pointer;
        logic [7:0] x;
        ctl_wr(1'b1, 8'h09);
        ctl_rd(1'b1, x); chk("R1 high bank reg9 read", x, 8'h00);
        ctl_rd(1'b1, x); chk("R1 ptr zero after read", x, 8'h44);
        ctl_wr(1'b1, 8'h01); ctl_wr(1'b1, 8'h12);
        ctl_rd(1'b1, x); chk("R1 ptr zero after write", x, 8'h44);
        wr_reg(1'b1, 3, 8'h01);
        wr_reg(1'b0, 1, 8'h12);
        wr_reg(1'b0, 3, 8'h01);
    endtask

    task automatic t_rx_low;
        logic [7:0] x;
        push(1'b1, 8'h5A);
        chk("R3 irq on rx", {7'b0, irq}, 8'h01);
        chk_vec("R4 A rx vector", 8'h0C);
        chk_pend("R6 A rx pending", 8'h20);
        rd_reg(1'b1, 0, x); chk("R11 rx available", x, 8'h45);
        dat_rd(1'b1, x); chk("R10 rx byte", x, 8'h5A);
        chk_vec("R4 none vector", 8'h06);
        chk_pend("R10 pending cleared", 8'h00);
        rd_reg(1'b1, 0, x); chk("R10 avail cleared", x, 8'h44);
        chk("R10 irq dropped", {7'b0, irq}, 8'h00);
        push(1'b0, 8'h3C);
        chk_vec("R4 B rx vector", 8'h04);
        chk_pend("R6 B rx pending", 8'h04);
        dat_rd(1'b0, x); chk("R10 B rx byte", x, 8'h3C);
    endtask

    task automatic t_overrun;
        logic [7:0] x;
        push(1'b1, 8'h11);
        push(1'b1, 8'h22);
        dat_rd(1'b1, x); chk("R11 second push ignored", x, 8'h11);
    endtask

    task automatic t_tx_low;
        logic [7:0] x;
        dat_wr(1'b0, 8'h33);
        chk_vec("R4 B tx vector", 8'h00);
        chk_pend("R6 B tx pending", 8'h02);
        rd_reg(1'b0, 0, x); chk("R10 tx empty", x & 8'h04, 8'h04);
        chk("R3 irq on tx", {7'b0, irq}, 8'h01);
        ctl_wr(1'b0, 8'h28);
        chk_vec("R9 clear tx vector", 8'h06);
        chk_pend("R9 clear tx pending", 8'h00);
        chk("R9 irq dropped", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_defer;
        logic [7:0] x;
        push(1'b1, 8'h44);
        dat_wr(1'b1, 8'h55);
        chk_vec("R7 tx deferred vector", 8'h0C);
        chk_pend("R7 tx deferred pending", 8'h20);
        ctl_wr(1'b1, 8'h38);
        chk_vec("R8 tx raised by reset-ius", 8'h08);
        chk_pend("R8 pending after reset-ius", 8'h30);
        ctl_wr(1'b1, 8'h38);
        chk_vec("R8 tx service ended vector kept", 8'h08);
        dat_rd(1'b1, x); chk("R10 deferred byte", x, 8'h44);
        chk_vec("R8 tx after rx read", 8'h08);
        chk_pend("R8 pending after rx read", 8'h10);
        ctl_wr(1'b1, 8'h28);
        chk_vec("R9 A clear tx", 8'h06);
        chk_pend("R9 A pending clear", 8'h00);
        chk("R9 irq low", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_high;
        logic [7:0] x;
        wr_reg(1'b1, 9, 8'h10);
        wr_reg(1'b0, 9, 8'h10);
        push(1'b1, 8'h01);
        chk_vec("R5 A rx vector", 8'h30);
        dat_rd(1'b1, x);
        chk_vec("R5 none vector", 8'h60);
        push(1'b0, 8'h02);
        chk_vec("R5 B rx vector", 8'h20);
        dat_rd(1'b0, x);
        dat_wr(1'b0, 8'h03);
        chk_vec("R5 B tx vector", 8'h00);
        ctl_wr(1'b0, 8'h28);
        dat_wr(1'b1, 8'h04);
        chk_vec("R5 A tx vector", 8'h10);
        ctl_wr(1'b1, 8'h28);
        chk_vec("R5 none after clear", 8'h60);
    endtask

    task automatic t_tx_masked;
        wr_reg(1'b1, 1, 8'h10);
        dat_wr(1'b1, 8'h66);
        chk_pend("R6 tx bit needs enable", 8'h00);
        chk_vec("R6 vector still updated", 8'h10);
        chk("R3 irq needs tx enable", {7'b0, irq}, 8'h00);
        ctl_wr(1'b1, 8'h28);
        wr_reg(1'b1, 1, 8'h12);
    endtask

    task automatic t_same_cycle;
        logic [7:0] x;
        @(negedge clk);
        acc_en = 1'b1; acc_sel_a = 1'b0; acc_ctrl = 1'b0; acc_wr = 1'b1; acc_wdata = 8'h77;
        rx_push[1] = 1'b1; rx_data_a = 8'h88;
        @(posedge clk);
        #1 begin acc_en = 1'b0; rx_push = '0; end
        chk_vec("R13 A wins vector", 8'h30);
        chk_pend("R13 both pending", 8'h22);
        chk("R13 irq", {7'b0, irq}, 8'h01);
        dat_rd(1'b1, x); chk("R13 A byte", x, 8'h88);
        ctl_wr(1'b0, 8'h28);
        chk_vec("R13 cleanup vector", 8'h60);
        chk_pend("R13 cleanup pending", 8'h00);
    endtask

    task automatic t_break;
        logic [7:0] x;
        @(negedge clk); brk_set[0] = 1'b1;
        @(posedge clk); #1 brk_set = '0;
        rd_reg(1'b0, 0, x); chk("R14 break status", x, 8'hC4);
        chk("R3 irq on break", {7'b0, irq}, 8'h01);
        wr_reg(1'b0, 15, 8'h00);
        chk("R3 break masked", {7'b0, irq}, 8'h00);
        rd_reg(1'b0, 0, x); chk("R14 break held", x, 8'hC4);
    endtask

    task automatic t_chan_reset;
        logic [7:0] x;
        wr_reg(1'b1, 9, 8'h40);
        rd_reg(1'b0, 0, x); chk("R12 B reset status", x, 8'h44);
        chk_vec("R12 B reset vector", 8'h00);
        push(1'b0, 8'h99);
        rd_reg(1'b0, 0, x); chk("R12 B rx disabled after reset", x, 8'h44);
        push(1'b1, 8'h5C);
        chk_vec("R12 A kept high variant", 8'h30);
        wr_reg(1'b1, 9, 8'hC0);
        chk_vec("R12 both reset vector", 8'h00);
        chk_pend("R12 both reset pending", 8'h00);
        rd_reg(1'b1, 0, x); chk("R12 A reset status", x, 8'h44);
        chk("R12 irq low", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_push_disabled();
        t_pointer();
        t_rx_low();
        t_overrun();
        t_tx_low();
        t_defer();
        t_high();
        t_tx_masked();
        t_same_cycle();
        t_break();
        t_chan_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule